// File: doc/BRIEF.md
# Tape controller register interface

This block sits between a host processor's I/O instruction decoder and a two-drive cassette tape transfer sequencer. Each host I/O strobe carries a 3-bit function code and the 12-bit accumulator. The block answers with a skip pulse, a replacement accumulator value, or an effect on its registers.

It holds the command register: enable, drive select, tape operation and interrupt enable. It keeps the sticky error flags and the data flag, which the sequencer sets through event pulses. It merges these with live drive state (attached, write-protected, busy) into an 8-bit status word that the host can read. It also drives a level interrupt request.

A go request either launches a new operation, which is a pulse to the sequencer, or continues the one in progress. Write-type operations aimed at a protected cartridge are refused and flagged. The tape mechanics, data path and CRC all live in the sequencer.

Top module: `tape_ctl_regif`

## Requirements
- R1: After reset the command register, all sticky flags and the data flag are zero, `irq` is low and a status read returns 0.
- R2: Function 4 stores `acc_in[7:0]` in the command register (bit 7 enable, bit 6 drive select, bits 5:3 operation, bit 0 interrupt enable) and returns `{4'h0, acc_in[7:0] ^ 8'hFF}` on `acc_out` in the strobe cycle.
- R3: Function 7 returns status bits 7:0 on `acc_out[7:0]` with zeros above, and returns 0 whenever enable is clear. The write-lock error flag (status bit 8) never appears in this read.
- R4: The observed drive is the lowest-numbered busy drive, or the selected drive if none is busy. Live bits are: empty (bit 3) = not attached; write locked (bit 1) = not attached, protected or rewinding; ready (bit 0) = not busy.
- R5: `skip` pulses only in a strobe cycle. Function 1 skips on the data flag. Function 2 skips on any error (bits 8,7,6,5,4,3). Function 3 skips on ready and not empty. Function 5 skips on data flag, any error or ready.
- R6: Function 6 always clears the data flag. If any drive is busy it pulses `go_cont`, does not pulse `go_start`, and leaves the error flags unchanged.
- R7: A go with no drive busy, enable set and the selected drive attached clears the write-lock (8), CRC (7), timing (6), end-of-file (4), rewinding (2) and BOT/EOT (5) flags and pulses `go_start`. Operation 1 (rewind) then sets rewinding.
- R8: A go for operation 2 or 4 on a protected selected drive sets the write-lock error flag and produces no `go_start`.
- R9: A go with enable clear, or with the selected drive unattached, produces neither pulse.
- R10: A data event sets the data flag. If the data flag was already set, it also sets the timing error (bit 6).
- R11: `irq` is high exactly when interrupt enable is set and the data flag, any visible error or visible ready is present.
- R12: Function 0 pulses `ctl_clear` and clears the command register, every sticky flag and the data flag.
- R13: Rewinding (bit 2) is shown only while the observed drive is attached and busy. It is forgotten once that drive is seen idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fn_valid | input | 1 | Host I/O strobe, one cycle |
| fn_code | input | 3 | Host function code |
| acc_in | input | 12 | Accumulator value from host |
| drv_attached | input | 2 | Per-drive cartridge present |
| drv_wprot | input | 2 | Per-drive write protect |
| drv_busy | input | 2 | Per-drive operation active |
| ev_data_flag | input | 1 | Sequencer: character ready / taken |
| ev_crc_err | input | 1 | Sequencer: CRC or medium error |
| ev_beot | input | 1 | Sequencer: tape end reached |
| ev_eof | input | 1 | Sequencer: file gap found |
| skip | output | 1 | Skip request, strobe cycle only |
| acc_out | output | 12 | Accumulator value returned to host |
| go_start | output | 1 | Launch a new operation |
| go_cont | output | 1 | Continue the running operation |
| go_unit | output | 1 | Drive selected in the command register |
| go_op | output | 3 | Operation in the command register |
| ctl_clear | output | 1 | Controller clear to the sequencer |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties check the following on every cycle: skip confinement to strobes, command capture, timing-error setting on overrun, the clear and data-flag drop after a go, the refusal of protected writes, the interrupt gate and the forgetting of the rewind flag. The bench sweeps every combination of attached, protected and busy state for both drives under both selections and both enable values. It compares the status word, the two status skips and the interrupt against values computed from the live-bit rules. Sequence-dependent behaviour can only be shown by the bench's scenarios: rewind visibility across busy transitions, the flags a launch clears, the two-step timing error, and which go paths are refused.

// File: rtl/tctl_pkg.sv
package tctl_pkg;

  typedef enum logic [2:0] {
    HF_CLEAR   = 3'd0,
    HF_SKIP_DF = 3'd1,
    HF_SKIP_ER = 3'd2,
    HF_SKIP_RD = 3'd3,
    HF_LOAD_A  = 3'd4,
    HF_SKIP_AN = 3'd5,
    HF_GO      = 3'd6,
    HF_READ_B  = 3'd7
  } host_fn_e;

  typedef enum logic [2:0] {
    TOP_READ     = 3'd0,
    TOP_REWIND   = 3'd1,
    TOP_WRITE    = 3'd2,
    TOP_REV_FILE = 3'd3,
    TOP_GAP      = 3'd4,
    TOP_REV_BLK  = 3'd5,
    TOP_CHECK    = 3'd6,
    TOP_FWD_FILE = 3'd7
  } tape_op_e;

  localparam int CMD_W    = 8;
  localparam int STAT_W   = 9;
  localparam int CA_EN    = 7;
  localparam int CA_UNIT  = 6;
  localparam int CA_OP_LO = 3;
  localparam int CA_IE    = 0;

  localparam int SB_WLE  = 8;
  localparam int SB_CRC  = 7;
  localparam int SB_TIM  = 6;
  localparam int SB_BEOT = 5;
  localparam int SB_EOF  = 4;
  localparam int SB_EMP  = 3;
  localparam int SB_REW  = 2;
  localparam int SB_WLK  = 1;
  localparam int SB_RDY  = 0;

  localparam logic [STAT_W-1:0] ERR_MASK = 9'b1_1111_1000;

  typedef struct packed {
    logic wle;
    logic crc;
    logic tim;
    logic beot;
    logic eof;
    logic rew;
  } sticky_t;

  function automatic logic op_writes(tape_op_e op);
    return (op == TOP_WRITE) || (op == TOP_GAP);
  endfunction

endpackage

// File: rtl/tctl_drive_view.sv
module tctl_drive_view #(
  parameter int NUM_DRIVES = 2,
  localparam int UNIT_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic [UNIT_W-1:0]     sel_unit,
  input  logic                  enable,
  input  logic [NUM_DRIVES-1:0] attached,
  input  logic [NUM_DRIVES-1:0] wprot,
  input  logic [NUM_DRIVES-1:0] busy,
  output logic                  obs_valid,
  output logic                  obs_att,
  output logic                  obs_wp,
  output logic                  obs_busy,
  output logic                  any_busy,
  output logic                  sel_att,
  output logic                  sel_wp
);

  logic [UNIT_W-1:0] busy_idx;
  logic              busy_found;
  logic [UNIT_W-1:0] obs_idx;

  // Lowest-numbered busy drive wins: scan from the top down.
  always_comb begin
    busy_idx   = '0;
    busy_found = 1'b0;
    for (int i = NUM_DRIVES - 1; i >= 0; i--) begin
      if (busy[i]) begin
        busy_idx   = UNIT_W'(i);
        busy_found = 1'b1;
      end
    end
  end

  assign any_busy  = busy_found;
  assign obs_idx   = busy_found ? busy_idx : sel_unit;
  assign obs_valid = busy_found | enable;
  assign obs_att   = attached[obs_idx];
  assign obs_wp    = wprot[obs_idx];
  assign obs_busy  = busy[obs_idx];
  assign sel_att   = attached[sel_unit];
  assign sel_wp    = wprot[sel_unit];

endmodule

// File: rtl/tctl_status.sv
module tctl_status
  import tctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              go_clr_df,
  input  logic              xfr_clr,
  input  logic              set_wle,
  input  logic              launch,
  input  logic              launch_rew,
  input  logic              ev_df,
  input  logic              ev_crc,
  input  logic              ev_beot,
  input  logic              ev_eof,
  input  logic              obs_valid,
  input  logic              obs_att,
  input  logic              obs_wp,
  input  logic              obs_busy,
  output logic [STAT_W-1:0] sb_full,
  output logic              df
);

  sticky_t st_q, st_d;
  logic    df_q, df_d;
  logic    st_en;
  logic    rew_shown, live_emp, live_wlk, live_rdy;

  // Next-state: clears first, then sets, then the controller clear.
  always_comb begin
    st_d = st_q;
    df_d = df_q;
    if (obs_valid && (!obs_att || !obs_busy)) st_d.rew = 1'b0;
    if (go_clr_df) df_d = 1'b0;
    if (xfr_clr) begin
      st_d.wle = 1'b0;
      st_d.crc = 1'b0;
      st_d.tim = 1'b0;
      st_d.eof = 1'b0;
      st_d.rew = 1'b0;
    end
    if (set_wle) st_d.wle = 1'b1;
    if (launch) begin
      st_d.beot = 1'b0;
      if (launch_rew) st_d.rew = 1'b1;
    end
    if (ev_df) begin
      if (df_q) st_d.tim = 1'b1;
      df_d = 1'b1;
    end
    if (ev_crc)  st_d.crc  = 1'b1;
    if (ev_beot) st_d.beot = 1'b1;
    if (ev_eof)  st_d.eof  = 1'b1;
    if (clr_all) begin
      st_d = '0;
      df_d = 1'b0;
    end
  end

  assign st_en = (st_d != st_q) || (df_d != df_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      df_q <= 1'b0;
    end else if (st_en) begin
      st_q <= st_d;
      df_q <= df_d;
    end
  end

  assign rew_shown = st_q.rew & obs_valid & obs_att & obs_busy;
  assign live_emp  = obs_valid & ~obs_att;
  assign live_wlk  = obs_valid & (~obs_att | obs_wp | rew_shown);
  assign live_rdy  = obs_valid & ~obs_busy;

  assign sb_full = {st_q.wle, st_q.crc, st_q.tim, st_q.beot, st_q.eof,
                    live_emp, rew_shown, live_wlk, live_rdy};
  assign df = df_q;

  a_r10_overrun_sets_timing: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_df && df_q && !clr_all) |=> st_q.tim);

  a_r6_go_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (go_clr_df && !ev_df && !clr_all) |=> !df_q);

  a_r12_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (st_q == '0 && !df_q));

  a_r13_rew_forgotten_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (obs_valid && !obs_busy && !(launch && launch_rew)) |=> !st_q.rew);

endmodule

// File: rtl/tctl_host_decode.sv
module tctl_host_decode
  import tctl_pkg::*;
#(
  parameter int ACC_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fn_valid,
  input  logic [2:0]        fn_code,
  input  logic [ACC_W-1:0]  acc_in,
  input  logic [STAT_W-1:0] sb_vis,
  input  logic              df,
  output logic              skip,
  output logic [ACC_W-1:0]  acc_out,
  output logic              do_clear,
  output logic              do_load_a,
  output logic              do_go
);

  localparam int PAD_W = ACC_W - CMD_W;

  logic any_err, rdy, emp;
  host_fn_e fn;

  assign fn      = host_fn_e'(fn_code);
  assign any_err = |(sb_vis & ERR_MASK);
  assign rdy     = sb_vis[SB_RDY];
  assign emp     = sb_vis[SB_EMP];

  always_comb begin
    skip      = 1'b0;
    acc_out   = acc_in;
    do_clear  = 1'b0;
    do_load_a = 1'b0;
    do_go     = 1'b0;
    if (fn_valid) begin
      case (fn)
        HF_CLEAR:   do_clear = 1'b1;
        HF_SKIP_DF: skip = df;
        HF_SKIP_ER: skip = any_err;
        HF_SKIP_RD: skip = rdy & ~emp;
        HF_LOAD_A: begin
          do_load_a = 1'b1;
          acc_out   = {{PAD_W{1'b0}}, ~acc_in[CMD_W-1:0]};
        end
        HF_SKIP_AN: skip = df | any_err | rdy;
        HF_GO:      do_go = 1'b1;
        HF_READ_B:  acc_out = {{PAD_W{1'b0}}, sb_vis[CMD_W-1:0]};
        default:    skip = 1'b0;
      endcase
    end
  end

  a_r5_skip_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !fn_valid |-> !skip);

  a_r3_read_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_valid && fn_code == 3'd7) |-> (acc_out[ACC_W-1:CMD_W] == '0));

endmodule

// File: rtl/tape_ctl_regif.sv
module tape_ctl_regif
  import tctl_pkg::*;
#(
  parameter int NUM_DRIVES = 2,
  parameter int ACC_W      = 12,
  localparam int UNIT_W    = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fn_valid,
  input  logic [2:0]            fn_code,
  input  logic [ACC_W-1:0]      acc_in,
  input  logic [NUM_DRIVES-1:0] drv_attached,
  input  logic [NUM_DRIVES-1:0] drv_wprot,
  input  logic [NUM_DRIVES-1:0] drv_busy,
  input  logic                  ev_data_flag,
  input  logic                  ev_crc_err,
  input  logic                  ev_beot,
  input  logic                  ev_eof,
  output logic                  skip,
  output logic [ACC_W-1:0]      acc_out,
  output logic                  go_start,
  output logic                  go_cont,
  output logic [UNIT_W-1:0]     go_unit,
  output logic [2:0]            go_op,
  output logic                  ctl_clear,
  output logic                  irq
);

  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic              cmd_en;
  logic              do_clear, do_load_a, do_go;
  logic              obs_valid, obs_att, obs_wp, obs_busy;
  logic              any_busy, sel_att, sel_wp;
  logic [STAT_W-1:0] sb_full, sb_vis;
  logic              df;
  logic              go_new, wp_abort;
  logic              cmd_enable, cmd_ie;
  tape_op_e          cmd_op;

  assign cmd_enable = cmd_q[CA_EN];
  assign cmd_ie     = cmd_q[CA_IE];
  assign cmd_op     = tape_op_e'(cmd_q[CA_OP_LO +: 3]);
  assign go_unit    = cmd_q[CA_UNIT +: UNIT_W];
  assign go_op      = cmd_q[CA_OP_LO +: 3];

  // Command register
  always_comb begin
    cmd_en = do_clear | do_load_a;
    cmd_d  = do_clear ? '0 : acc_in[CMD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_en) cmd_q <= cmd_d;
  end

  tctl_drive_view #(.NUM_DRIVES(NUM_DRIVES)) u_view (
    .sel_unit  (go_unit),
    .enable    (cmd_enable),
    .attached  (drv_attached),
    .wprot     (drv_wprot),
    .busy      (drv_busy),
    .obs_valid (obs_valid),
    .obs_att   (obs_att),
    .obs_wp    (obs_wp),
    .obs_busy  (obs_busy),
    .any_busy  (any_busy),
    .sel_att   (sel_att),
    .sel_wp    (sel_wp)
  );

  // Go dispatch
  always_comb begin
    go_cont  = do_go & any_busy;
    go_new   = do_go & ~any_busy & cmd_enable & sel_att;
    wp_abort = go_new & op_writes(cmd_op) & sel_wp;
    go_start = go_new & ~wp_abort;
  end

  tctl_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_all    (do_clear),
    .go_clr_df  (do_go),
    .xfr_clr    (go_new),
    .set_wle    (wp_abort),
    .launch     (go_start),
    .launch_rew (cmd_op == TOP_REWIND),
    .ev_df      (ev_data_flag),
    .ev_crc     (ev_crc_err),
    .ev_beot    (ev_beot),
    .ev_eof     (ev_eof),
    .obs_valid  (obs_valid),
    .obs_att    (obs_att),
    .obs_wp     (obs_wp),
    .obs_busy   (obs_busy),
    .sb_full    (sb_full),
    .df         (df)
  );

  assign sb_vis = cmd_enable ? sb_full : '0;

  tctl_host_decode #(.ACC_W(ACC_W)) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .fn_valid  (fn_valid),
    .fn_code   (fn_code),
    .acc_in    (acc_in),
    .sb_vis    (sb_vis),
    .df        (df),
    .skip      (skip),
    .acc_out   (acc_out),
    .do_clear  (do_clear),
    .do_load_a (do_load_a),
    .do_go     (do_go)
  );

  assign ctl_clear = do_clear;
  assign irq = cmd_ie & (df | (|(sb_vis & (ERR_MASK | STAT_W'(1)))));

  a_r2_load_captures: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_valid && fn_code == 3'd4) |=> (cmd_q == $past(acc_in[CMD_W-1:0])));

  a_r8_protected_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    go_start |-> !((go_op == 3'd2 || go_op == 3'd4) && drv_wprot[go_unit]));

  a_r9_start_needs_enable_and_media: assert property (@(posedge clk) disable iff (!rst_n)
    go_start |-> (cmd_q[CA_EN] && drv_attached[go_unit] && drv_busy == '0));

  a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_q[CA_IE] |-> !irq);

  a_r6_single_go_path: assert property (@(posedge clk) disable iff (!rst_n)
    !(go_start && go_cont));

endmodule

// File: tb/tape_ctl_regif_tb.sv
module tape_ctl_regif_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fn_valid;
  logic [2:0]  fn_code;
  logic [11:0] acc_in;
  logic [1:0]  att, wp, busy;
  logic        ev_df, ev_crc, ev_beot, ev_eof;
  logic        skip, go_start, go_cont, ctl_clear, irq;
  logic [11:0] acc_out;
  logic [0:0]  go_unit;
  logic [2:0]  go_op;

  int n_chk = 0;
  int n_fail = 0;
  logic        c_skip, c_gs, c_gc, c_clr, c_irq;
  logic [11:0] c_acc;

  always #10 clk = ~clk;

  tape_ctl_regif u_dut (
    .clk(clk), .rst_n(rst_n), .fn_valid(fn_valid), .fn_code(fn_code),
    .acc_in(acc_in), .drv_attached(att), .drv_wprot(wp), .drv_busy(busy),
    .ev_data_flag(ev_df), .ev_crc_err(ev_crc), .ev_beot(ev_beot), .ev_eof(ev_eof),
    .skip(skip), .acc_out(acc_out), .go_start(go_start), .go_cont(go_cont),
    .go_unit(go_unit), .go_op(go_op), .ctl_clear(ctl_clear), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_fn(input logic [2:0] c, input logic [11:0] a);
    @(negedge clk);
    fn_valid = 1'b1; fn_code = c; acc_in = a;
    #2;
    c_skip = skip; c_acc = acc_out; c_gs = go_start; c_gc = go_cont;
    c_clr = ctl_clear; c_irq = irq;
    @(negedge clk);
    fn_valid = 1'b0; acc_in = '0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: ev_df = 1'b1;
      1: ev_crc = 1'b1;
      2: ev_beot = 1'b1;
      default: ev_eof = 1'b1;
    endcase
    @(negedge clk);
    ev_df = 1'b0; ev_crc = 1'b0; ev_beot = 1'b0; ev_eof = 1'b0;
  endtask

  function automatic logic [11:0] mk_a(input int en, input int u, input int op, input int ie);
    return {4'h0, en[0], u[0], op[2:0], 2'b00, ie[0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fn_valid = 1'b0; fn_code = '0; acc_in = '0;
    att = 2'b11; wp = 2'b00; busy = 2'b00;
    ev_df = 0; ev_crc = 0; ev_beot = 0; ev_eof = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk("R1 irq after reset", irq, 0);
    chk("R1 go_start idle", go_start, 0);
    do_fn(3'd7, 12'h000);
    chk("R1 status read", c_acc, 0);
    chk("R5 skip outside strobe", skip, 0);

    // R2 load/complement and its effect
    foreach (u_vals[k]) begin end
    for (int k = 0; k < 4; k++) begin
      logic [11:0] v;
      v = (k == 0) ? 12'hFFF : (k == 1) ? 12'h000 : (k == 2) ? 12'h5A3 : 12'hA5C;
      do_fn(3'd4, v);
      chk("R2 load returns complement", c_acc, {4'h0, ~v[7:0]});
      do_fn(3'd7, 12'h000);
      chk("R2 enable effect on status", c_acc, v[7] ? 1 : 0);
      chk("R11 irq after load", c_irq, v[7] & v[0]);
    end

    // Sweep of drive states, selection and enable (R3, R4, R5, R11)
    for (int en = 0; en < 2; en++) begin
      for (int u = 0; u < 2; u++) begin
        for (int d = 0; d < 64; d++) begin
          int o;
          logic emp, wlk, rdy;
          att = d[1:0]; wp = d[3:2]; busy = d[5:4];
          do_fn(3'd4, mk_a(en, u, 0, 1));
          o = busy[0] ? 0 : (busy[1] ? 1 : u);
          emp = ~att[o]; wlk = ~att[o] | wp[o]; rdy = ~busy[o];
          do_fn(3'd7, 12'h000);
          chk("R4 live status bits", c_acc, en ? {emp, 1'b0, wlk, rdy} : 0);
          chk("R11 irq from live bits", c_irq, en ? (emp | rdy) : 0);
          do_fn(3'd3, 12'h000);
          chk("R5 ready skip", c_skip, en ? (rdy & ~emp) : 0);
          do_fn(3'd2, 12'h000);
          chk("R5 error skip", c_skip, en ? emp : 0);
        end
      end
    end
    att = 2'b11; wp = 2'b00; busy = 2'b00;
    do_fn(3'd0, 12'h000);

    // R7 launch clears transfer errors
    do_fn(3'd4, mk_a(1, 0, 0, 0));
    pulse(1);
    do_fn(3'd7, 12'h000);
    chk("R7 crc flag before go", c_acc, 12'h081);
    do_fn(3'd2, 12'h000);
    chk("R5 error skip on crc", c_skip, 1);
    do_fn(3'd6, 12'h000);
    chk("R7 go_start", c_gs, 1);
    chk("R7 no go_cont", c_gc, 0);
    do_fn(3'd7, 12'h000);
    chk("R7 crc cleared by launch", c_acc, 12'h001);

    // R13 rewind visibility
    do_fn(3'd4, mk_a(1, 0, 1, 0));
    do_fn(3'd6, 12'h000);
    busy = 2'b01;
    chk("R7 rewind launch", c_gs, 1);
    do_fn(3'd7, 12'h000);
    chk("R13 rewinding shown with lock", c_acc, 12'h006);
    busy = 2'b00;
    do_fn(3'd7, 12'h000);
    chk("R13 idle drive clears rewinding", c_acc, 12'h001);
    busy = 2'b01;
    do_fn(3'd7, 12'h000);
    chk("R13 rewinding stays forgotten", c_acc, 12'h000);
    busy = 2'b00;

    // BOT/EOT flag cleared by launch
    do_fn(3'd4, mk_a(1, 0, 0, 0));
    pulse(2);
    do_fn(3'd7, 12'h000);
    chk("R7 tape end flag", c_acc, 12'h021);
    do_fn(3'd6, 12'h000);
    do_fn(3'd7, 12'h000);
    chk("R7 tape end cleared", c_acc, 12'h001);

    // R8 protected writes
    wp = 2'b01;
    do_fn(3'd4, mk_a(1, 0, 2, 0));
    do_fn(3'd6, 12'h000);
    chk("R8 write refused", c_gs, 0);
    do_fn(3'd7, 12'h000);
    chk("R3 lock error hidden in read", c_acc, 12'h003);
    do_fn(3'd2, 12'h000);
    chk("R8 lock error skips", c_skip, 1);
    do_fn(3'd4, mk_a(1, 0, 4, 0));
    do_fn(3'd6, 12'h000);
    chk("R8 gap write refused", c_gs, 0);
    do_fn(3'd4, mk_a(1, 0, 0, 0));
    do_fn(3'd6, 12'h000);
    chk("R8 read allowed on protected", c_gs, 1);
    do_fn(3'd2, 12'h000);
    chk("R7 lock error cleared", c_skip, 0);
    wp = 2'b10;
    do_fn(3'd4, mk_a(1, 0, 2, 0));
    do_fn(3'd6, 12'h000);
    chk("R8 other drive protection ignored", c_gs, 1);
    wp = 2'b00;

    // R6 go while busy
    busy = 2'b10;
    pulse(1);
    do_fn(3'd4, mk_a(1, 0, 0, 0));
    do_fn(3'd6, 12'h000);
    chk("R6 go_cont", c_gc, 1);
    chk("R6 no go_start", c_gs, 0);
    do_fn(3'd7, 12'h000);
    chk("R6 errors kept", c_acc, 12'h080);
    busy = 2'b00;
    do_fn(3'd0, 12'h000);
    chk("R12 clear pulse", c_clr, 1);
    do_fn(3'd7, 12'h000);
    chk("R12 status after clear", c_acc, 0);

    // R9 refused starts
    do_fn(3'd4, mk_a(0, 0, 0, 0));
    do_fn(3'd6, 12'h000);
    chk("R9 disabled go", c_gs | c_gc, 0);
    att = 2'b10;
    do_fn(3'd4, mk_a(1, 0, 0, 0));
    do_fn(3'd6, 12'h000);
    chk("R9 unattached go", c_gs | c_gc, 0);
    att = 2'b11;

    // R10 data flag and timing error
    busy = 2'b01;
    do_fn(3'd4, mk_a(1, 0, 0, 1));
    do_fn(3'd1, 12'h000);
    chk("R11 no flag no irq", c_irq, 0);
    chk("R5 no data flag skip", c_skip, 0);
    pulse(0);
    do_fn(3'd1, 12'h000);
    chk("R10 data flag skip", c_skip, 1);
    chk("R11 irq from data flag", c_irq, 1);
    do_fn(3'd5, 12'h000);
    chk("R5 any skip", c_skip, 1);
    pulse(0);
    do_fn(3'd7, 12'h000);
    chk("R10 timing error", c_acc, 12'h040);
    do_fn(3'd6, 12'h000);
    chk("R6 go_cont with flag", c_gc, 1);
    do_fn(3'd1, 12'h000);
    chk("R6 go clears data flag", c_skip, 0);
    do_fn(3'd2, 12'h000);
    chk("R6 timing error kept", c_skip, 1);
    busy = 2'b00;

    // R12 clear with state present
    do_fn(3'd0, 12'h000);
    chk("R12 clear pulse again", c_clr, 1);
    do_fn(3'd7, 12'h000);
    chk("R12 enable cleared", c_acc, 0);
    chk("R12 irq low", c_irq, 0);
    do_fn(3'd4, mk_a(1, 0, 0, 0));
    do_fn(3'd7, 12'h000);
    chk("R12 sticky flags cleared", c_acc, 12'h001);

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  int u_vals [1];

endmodule